// File: doc/BRIEF.md
# Two-Stage Load-Balanced Cell Switch

This block is an N-port cell switch, N = 4 by default. It moves fixed-size cells in time slots of one clock cycle each, through two crossbars that need no arbitration. Every input port keeps one FIFO queue per destination output. A middle stage of N chamber queues sits between the two crossbars. Each chamber has one single-cell bank per output. Both crossbars follow a fixed cyclic schedule that is driven by a modulo-N slot counter. In slot t, input i is joined to chamber (i + t) mod N, and chamber j is joined to output (t − j) mod N. With this pairing, a cell waits in a chamber for a time that depends only on its input and output. Cells of one flow therefore leave in order, with no resequencing logic.

A source presents a cell on its input with a destination tag and a payload. The cell is taken when ready is high. The input stamps the cell with a per-flow sequence number. In each slot, an input moves at most one cell into the bank for that cell's destination in its connected chamber, and only when that bank is empty. Among the eligible destinations, the input picks one in round-robin order. Each chamber hands the cell in the bank of its connected output to that output, and the bank becomes free for the next slot. An output presents a delivered cell for one cycle, with the source index, the sequence number and the payload.

Top module: `lbsw_switch`

## Requirements
- R1: After reset, every out_valid bit is 0, every in_ready bit is 1, and the slot counter starts at 0.
- R2: For input i, in_ready is 0 exactly when the queue for in_dest already holds VOQ_DEPTH (8) cells. A write offered while in_ready is 0 is dropped and never delivered. The ready of one destination does not depend on how full the other queues of the same input are.
- R3: Each accepted cell is delivered exactly once, on the output named by its destination tag. An output shows a cell only in the cycle after exactly one chamber gave up a cell for that output.
- R4: Sequence numbers are SEQ_W (8) bits wide and start at 0 after reset for each (input, output) pair. They increase by 1 modulo 256 for each accepted cell, and cells of one pair are delivered in rising sequence order.
- R5: A delivered cell carries on out_src the index of the input that wrote it, and on out_data the unchanged 16-bit payload.
- R6: The schedule joins input i to chamber (i+t) mod N and chamber j to output (t−j) mod N. On an otherwise idle switch, a cell from input i to output o is therefore loaded into the output register 2 + ((i+o+N−1) mod N) clock edges after the edge that accepted it.
- R7: Each chamber receives at most one cell per slot, and at most one chamber gives up a cell for a given output per slot.
- R8: A cell enters a bank only when that bank is empty, and a full bank stays full until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-input cell offer |
| in_dest | input | N*log2(N) | Per-input destination output index |
| in_data | input | N*DATA_W | Per-input payload |
| in_ready | output | N | Queue for the offered destination has room |
| out_valid | output | N | Per-output cell present, one cycle per cell |
| out_src | output | N*log2(N) | Input index of the delivered cell |
| out_seq | output | N*SEQ_W | Per-flow sequence number of the delivered cell |
| out_data | output | N*DATA_W | Payload of the delivered cell |

## Verification
Uniform random traffic spreads cells over all sixteen flows. It checks that cells routed through different chambers still come out in order and arrive exactly once. Hot-spot traffic pushes every input toward one output until its queues fill. This separates a correct ready and drop path from one that overwrites or loses cells, and shows that a full queue does not block the other destinations of the same input. Single cells sent into an idle switch give exact latencies for several input and output pairs, so a wrong connection pattern or a wrong slot phase shows up as a wrong cycle count.

// File: rtl/lbsw_pkg.sv
`timescale 1ns/1ps
package lbsw_pkg;

  // (a + b) mod n for operands already below n
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // (a - b) mod n for operands already below n
  function automatic int wrap_sub(input int a, input int b, input int n);
    int s;
    s = a - b;
    if (s < 0) s = s + n;
    return s;
  endfunction

endpackage

// File: rtl/lbsw_fifo.sv
`timescale 1ns/1ps
module lbsw_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         pop,
  output logic [W-1:0] head_word,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign head_word = mem[rd_q];

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (push) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_word;
  end
endmodule

// File: rtl/lbsw_ingress.sv
`timescale 1ns/1ps
module lbsw_ingress #(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  parameter int SW    = 8,
  parameter int PW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [$clog2(N)-1:0]   wr_dest,
  input  logic [PW-1:0]          wr_data,
  output logic                   wr_ready,
  input  logic [N-1:0]           bank_busy,
  output logic                   mv_valid,
  output logic [$clog2(N)-1:0]   mv_dest,
  output logic [SW+PW-1:0]       mv_word
);
  localparam int DW = $clog2(N);
  localparam int FW = SW + PW;

  logic [N-1:0]  q_empty, q_full, push, pop;
  logic [FW-1:0] q_head [N];
  logic [SW-1:0] seq_q [N];
  logic [SW-1:0] seq_n [N];
  logic [DW-1:0] rr_q, rr_n;

  assign wr_ready = !q_full[wr_dest];

  for (genvar d = 0; d < N; d++) begin : g_voq
    assign push[d] = wr_valid && wr_ready && (wr_dest == DW'(d));
    assign seq_n[d] = push[d] ? seq_q[d] + 1'b1 : seq_q[d];
    lbsw_fifo #(.W(FW), .DEPTH(DEPTH)) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[d]),
      .push_word ({seq_q[d], wr_data}),
      .pop       (pop[d]),
      .head_word (q_head[d]),
      .empty     (q_empty[d]),
      .full      (q_full[d])
    );
  end

  // round-robin pick among destinations with a waiting cell and a free bank
  always_comb begin
    int idx;
    mv_valid = 1'b0;
    mv_dest  = '0;
    for (int k = 0; k < N; k++) begin
      idx = lbsw_pkg::wrap_add(int'(rr_q), k, N);
      if (!mv_valid && !q_empty[idx] && !bank_busy[idx]) begin
        mv_valid = 1'b1;
        mv_dest  = DW'(idx);
      end
    end
  end

  assign pop     = mv_valid ? (N'(1) << mv_dest) : '0;
  assign mv_word = q_head[mv_dest];
  assign rr_n    = mv_valid ? DW'(lbsw_pkg::wrap_add(int'(mv_dest), 1, N)) : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
      for (int d = 0; d < N; d++) seq_q[d] <= '0;
    end else begin
      rr_q <= rr_n;
      for (int d = 0; d < N; d++) seq_q[d] <= seq_n[d];
    end
  end
endmodule

// File: rtl/lbsw_chamber.sv
`timescale 1ns/1ps
module lbsw_chamber #(
  parameter int N  = 4,
  parameter int CW = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [$clog2(N)-1:0] wr_bank,
  input  logic [CW-1:0]        wr_cell,
  input  logic [$clog2(N)-1:0] srv_bank,
  output logic [N-1:0]         full,
  output logic [N-1:0]         rd,
  output logic                 srv_valid,
  output logic [CW-1:0]        srv_cell
);
  logic [N-1:0]  full_q, full_n, wr;
  logic [CW-1:0] bank_q [N];

  assign wr        = wr_valid ? (N'(1) << wr_bank) : '0;
  assign rd        = full_q & (N'(1) << srv_bank);
  assign full_n    = (full_q & ~rd) | wr;
  assign full      = full_q;
  assign srv_valid = |rd;
  assign srv_cell  = bank_q[srv_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_n;
  end

  for (genvar d = 0; d < N; d++) begin : g_bank
    always_ff @(posedge clk) begin
      if (wr[d]) bank_q[d] <= wr_cell;
    end
  end
endmodule

// File: rtl/lbsw_switch.sv
`timescale 1ns/1ps
module lbsw_switch #(
  parameter int N         = 4,
  parameter int VOQ_DEPTH = 8,
  parameter int SEQ_W     = 8,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                in_valid,
  input  logic [N*$clog2(N)-1:0]      in_dest,
  input  logic [N*DATA_W-1:0]         in_data,
  output logic [N-1:0]                in_ready,
  output logic [N-1:0]                out_valid,
  output logic [N*$clog2(N)-1:0]      out_src,
  output logic [N*SEQ_W-1:0]          out_seq,
  output logic [N*DATA_W-1:0]         out_data
);
  localparam int DW = $clog2(N);
  localparam int FW = SEQ_W + DATA_W;
  localparam int CW = DW + FW;

  logic [DW-1:0] slot_q, slot_n;

  logic [DW-1:0] ing_mid     [N];
  logic [N-1:0]  ing_busy    [N];
  logic          ing_mv_valid[N];
  logic [DW-1:0] ing_mv_dest [N];
  logic [FW-1:0] ing_mv_word [N];

  logic [DW-1:0] mid_src      [N];
  logic [DW-1:0] mid_srv      [N];
  logic [N-1:0]  mid_full     [N];
  logic [N-1:0]  mid_rd       [N];
  logic          mid_srv_valid[N];
  logic [CW-1:0] mid_srv_cell [N];

  logic [N*N-1:0] mid_full_flat, mid_wr_flat, mid_rd_flat;

  logic [N-1:0]  ov_n, ov_q;
  logic [CW-1:0] oc_n [N];
  logic [CW-1:0] oc_q [N];

  // slot counter steering both crossbars
  assign slot_n = DW'(lbsw_pkg::wrap_add(int'(slot_q), 1, N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_n;
  end

  // first stage: input i sees chamber (i + t) mod N
  for (genvar i = 0; i < N; i++) begin : g_in
    assign ing_mid[i]  = DW'(lbsw_pkg::wrap_add(int'(slot_q), i, N));
    assign ing_busy[i] = mid_full[ing_mid[i]];
    lbsw_ingress #(.N(N), .DEPTH(VOQ_DEPTH), .SW(SEQ_W), .PW(DATA_W)) i_ing (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (in_valid[i]),
      .wr_dest   (in_dest[i*DW +: DW]),
      .wr_data   (in_data[i*DATA_W +: DATA_W]),
      .wr_ready  (in_ready[i]),
      .bank_busy (ing_busy[i]),
      .mv_valid  (ing_mv_valid[i]),
      .mv_dest   (ing_mv_dest[i]),
      .mv_word   (ing_mv_word[i])
    );
  end

  // middle stage: chamber m fed by input (m - t), serving output (t - m)
  for (genvar m = 0; m < N; m++) begin : g_mid
    assign mid_src[m] = DW'(lbsw_pkg::wrap_sub(m, int'(slot_q), N));
    assign mid_srv[m] = DW'(lbsw_pkg::wrap_sub(int'(slot_q), m, N));
    lbsw_chamber #(.N(N), .CW(CW)) i_cq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (ing_mv_valid[mid_src[m]]),
      .wr_bank   (ing_mv_dest[mid_src[m]]),
      .wr_cell   ({mid_src[m], ing_mv_word[mid_src[m]]}),
      .srv_bank  (mid_srv[m]),
      .full      (mid_full[m]),
      .rd        (mid_rd[m]),
      .srv_valid (mid_srv_valid[m]),
      .srv_cell  (mid_srv_cell[m])
    );
    assign mid_full_flat[m*N +: N] = mid_full[m];
    assign mid_rd_flat[m*N +: N]   = mid_rd[m];
    assign mid_wr_flat[m*N +: N]   = ing_mv_valid[mid_src[m]] ?
                                     (N'(1) << ing_mv_dest[mid_src[m]]) : '0;
  end

  // second stage: output o takes chamber (t - o)
  for (genvar o = 0; o < N; o++) begin : g_out
    logic [DW-1:0] sel;
    assign sel     = DW'(lbsw_pkg::wrap_sub(int'(slot_q), o, N));
    assign ov_n[o] = mid_srv_valid[sel];
    assign oc_n[o] = mid_srv_cell[sel];

    always_ff @(posedge clk) begin
      if (ov_n[o]) oc_q[o] <= oc_n[o];
    end

    assign out_src[o*DW +: DW]         = oc_q[o][CW-1 -: DW];
    assign out_seq[o*SEQ_W +: SEQ_W]   = oc_q[o][FW-1 -: SEQ_W];
    assign out_data[o*DATA_W +: DATA_W] = oc_q[o][DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= '0;
    else        ov_q <= ov_n;
  end

  assign out_valid = ov_q;
endmodule

// File: rtl/lbsw_checker.sv
`timescale 1ns/1ps
module lbsw_checker #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   out_valid,
  input logic [N*N-1:0] mid_full_flat,
  input logic [N*N-1:0] mid_wr_flat,
  input logic [N*N-1:0] mid_rd_flat
);
  logic [N-1:0] col_rd [N];

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0));

  for (genvar m = 0; m < N; m++) begin : g_m
    assert_one_entry_per_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mid_wr_flat[m*N +: N]) <= 1);

    for (genvar d = 0; d < N; d++) begin : g_d
      assign col_rd[d][m] = mid_rd_flat[m*N + d];

      assert_fill_only_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mid_wr_flat[m*N + d] |-> !mid_full_flat[m*N + d]);

      assert_hold_until_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_full_flat[m*N + d] && !mid_rd_flat[m*N + d]) |=> mid_full_flat[m*N + d]);
    end
  end

  for (genvar o = 0; o < N; o++) begin : g_o
    assert_single_feeder_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col_rd[o]) <= 1);

    assert_valid_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> ($past($countones(col_rd[o])) == 1));

    assert_read_reaches_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(col_rd[o]) == 1) |=> out_valid[o]);
  end
endmodule

bind lbsw_switch lbsw_checker #(.N(N)) i_lbsw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .mid_full_flat (mid_full_flat),
  .mid_wr_flat   (mid_wr_flat),
  .mid_rd_flat   (mid_rd_flat)
);

// File: tb/test_lbsw_switch.sv
`timescale 1ns/1ps
module test_lbsw_switch;
  localparam int N  = 4;
  localparam int DW = 2;
  localparam int SW = 8;
  localparam int PW = 16;

  logic                clk, rst_n;
  logic [N-1:0]        in_valid, in_ready, out_valid;
  logic [N*DW-1:0]     in_dest, out_src;
  logic [N*PW-1:0]     in_data, out_data;
  logic [N*SW-1:0]     out_seq;

  lbsw_switch #(.N(N), .VOQ_DEPTH(8), .SEQ_W(SW), .DATA_W(PW)) i_lbsw_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_src(out_src), .out_seq(out_seq), .out_data(out_data)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 0;
  int tx_cnt [N][N];
  int rx_cnt [N][N];
  bit drv_v [N];
  int drv_d [N];
  int saw_block = 0;
  bit probe_en = 0;
  int split_seen = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] payload(input int s, input int d, input int q);
    int v;
    v = s * 40503 + d * 9973 + q * 131 + 7;
    return PW'(v ^ 16'hA5C3);
  endfunction

  // scoreboard: R3 exactly once on the right port, R4 order, R5 contents
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < N; o++) begin
        if (out_valid[o]) begin
          int s, q;
          s = int'(out_src[o*DW +: DW]);
          q = int'(out_seq[o*SW +: SW]);
          chk(rx_cnt[s][o] < tx_cnt[s][o], "R3", "delivered cell was sent",
              rx_cnt[s][o], tx_cnt[s][o]);
          chk(q == (rx_cnt[s][o] % 256), "R4", "per-flow sequence", q, rx_cnt[s][o] % 256);
          chk(out_data[o*PW +: PW] == payload(s, o, rx_cnt[s][o]), "R5", "payload/source",
              out_data[o*PW +: PW], payload(s, o, rx_cnt[s][o]));
          rx_cnt[s][o]++;
        end
      end
    end
  end

  task automatic drive_cycle();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_valid[i] = drv_v[i];
      in_dest[i*DW +: DW] = DW'(drv_d[i]);
      in_data[i*PW +: PW] = payload(i, drv_d[i], tx_cnt[i][drv_d[i]]);
    end
    #2;
    for (int i = 0; i < N; i++) begin
      if (drv_v[i] && in_ready[i])  tx_cnt[i][drv_d[i]]++;
      if (drv_v[i] && !in_ready[i]) saw_block++;
    end
    if (probe_en && !in_ready[0]) begin
      in_dest[0 +: DW] = DW'(1);
      #1;
      if (in_ready[0]) split_seen++;
      in_dest[0 +: DW] = DW'(drv_d[0]);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < N; i++) drv_v[i] = 0;
      drive_cycle();
    end
  endtask

  task automatic lat_test(input int s, input int o);
    int c0, lat, expl;
    bit seen;
    for (int i = 0; i < N; i++) begin drv_v[i] = (i == s); drv_d[i] = o; end
    drive_cycle();
    c0 = cyc;
    seen = 0;
    lat = -1;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      in_valid = '0;
      if (out_valid[o]) begin seen = 1; lat = cyc - c0 - 1; end
    end
    expl = 2 + ((s + o + N - 1) % N);
    chk(lat == expl, "R6", $sformatf("lone-cell latency %0d->%0d", s, o), lat, expl);
    for (int i = 0; i < N; i++) drv_v[i] = 0;
    idle(8);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < N; i++) for (int d = 0; d < N; d++) begin
      tx_cnt[i][d] = 0; rx_cnt[i][d] = 0;
    end
    for (int i = 0; i < N; i++) begin drv_v[i] = 0; drv_d[i] = 0; end
    in_valid = '0; in_dest = '0; in_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 15);

    // R6: lone cells through an idle switch
    lat_test(0, 0);
    lat_test(1, 2);
    lat_test(3, 0);
    lat_test(2, 3);
    lat_test(0, 1);
    lat_test(3, 3);

    // uniform random traffic (R3, R4, R5)
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) begin
        drv_v[i] = ($urandom % 100) < 55;
        drv_d[i] = $urandom % N;
      end
      drive_cycle();
    end
    idle(100);

    // hot-spot saturation on output 0 (R2)
    saw_block = 0;
    probe_en = 1;
    for (int k = 0; k < 200; k++) begin
      for (int i = 0; i < N; i++) begin drv_v[i] = 1; drv_d[i] = 0; end
      drive_cycle();
    end
    probe_en = 0;
    chk(saw_block > 0, "R2", "full queue refused writes", saw_block, 1);
    chk(split_seen > 0, "R2", "other destination still ready", split_seen, 1);
    idle(100);

    // skewed random traffic, 80% toward output 2
    for (int k = 0; k < 1500; k++) begin
      for (int i = 0; i < N; i++) begin
        drv_v[i] = ($urandom % 100) < 70;
        drv_d[i] = (($urandom % 100) < 80) ? 2 : int'($urandom % N);
      end
      drive_cycle();
    end
    idle(300);

    // R3: everything accepted came out, per flow
    for (int i = 0; i < N; i++)
      for (int d = 0; d < N; d++)
        chk(rx_cnt[i][d] == tx_cnt[i][d], "R3", $sformatf("flow %0d->%0d delivered", i, d),
            rx_cnt[i][d], tx_cnt[i][d]);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule